// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block is the clocked logic of a processor supervisor. It receives comparator results that are already digital: the supply is under the reset threshold, the supply is under the backup battery, and the power-fail sense is under its reference. From these it produces the reset lines, a low-line flag, a battery-on flag, a power-fail output and a gated chip-enable for the memory. The chip enable is blocked whenever the supply is low.

A watchdog watches a service input from the processor. Any change of level on that input restarts the timer. When the input holds one level for a full timeout, the watchdog output drops and a fixed-width reset pulse is issued. Another pulse follows after each further timeout while the watchdog stays unserviced.

The reset pulse width and the watchdog timeout are counted in clock ticks. A watchdog enable input stands in for detecting an undriven service input.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `rst` is high, the outputs sit at their safe values: `rst_n_o`=0, `rst_o`=1, `wd_n_o`=1, `ce_n_o`=1, `low_line_n_o`=0, `pf_n_o`=0 and `bat_on_o`=0.
- R2: If `vcc_low_i` or `vcc_below_bat_i` is sampled high at a clock edge, `rst_n_o` is 0 after that edge.
- R3: Take the first edge at which both supply flags are sampled low, or the first edge after `rst` falls. `rst_n_o` stays 0 for exactly RST_TICKS edges starting with that one, and then goes to 1.
- R4: `rst_o` is always the complement of `rst_n_o`. The two come from separate registers.
- R5: `wd_in_i` passes through a SYNC_STAGES-flop synchronizer. A level change of either direction is seen SYNC_STAGES+1 edges after the input changes, and it restarts the watchdog timer.
- R6: The watchdog is enabled and the supply is good. If no input change is seen for WD_TICKS edges, `wd_n_o` goes to 0. One edge later, a reset pulse starts and holds `rst_n_o` at 0 for RST_TICKS+1 edges.
- R7: While the watchdog stays unserviced, `wd_n_o` stays 0 and a new reset pulse starts every WD_TICKS edges.
- R8: `wd_n_o` returns to 1 on the edge where an input change is seen. It also returns to 1 on the edge after `vcc_low_i` or `vcc_below_bat_i` is sampled high.
- R9: When `wd_en_i` is sampled 0, the timer is held cleared and `wd_n_o` is 1 after that edge.
- R10: `low_line_n_o` is the registered inverse of (`vcc_low_i` OR `vcc_below_bat_i`).
- R11: `ce_n_o` is the registered copy of `ce_n_i` while `vcc_low_i` is 0. It is registered 1 while `vcc_low_i` is 1.
- R12: `pf_n_o` is the registered inverse of `pf_low_i`, but it is forced to 0 while `vcc_below_bat_i` is 1. `bat_on_o` is the registered copy of `vcc_below_bat_i`.
- R13: A service change seen on the same edge as an expiring timeout takes priority. No timeout is reported, so a service period of exactly WD_TICKS edges never lets `wd_n_o` fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_low_i | input | 1 | Supply is under the reset threshold |
| vcc_below_bat_i | input | 1 | Supply is under the backup battery |
| pf_low_i | input | 1 | Power-fail sense is under its reference |
| wd_in_i | input | 1 | Watchdog service input (asynchronous) |
| wd_en_i | input | 1 | Watchdog enable (0 means the service input is undriven) |
| ce_n_i | input | 1 | Chip enable in, active low |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| wd_n_o | output | 1 | Watchdog expired, active low |
| ce_n_o | output | 1 | Gated chip enable, active low |
| low_line_n_o | output | 1 | Low-line flag, active low |
| bat_on_o | output | 1 | Backup battery is supplying |
| pf_n_o | output | 1 | Power fail, active low |

## Verification
The assertions check the following on every cycle:
- the two reset lines stay complementary;
- supply faults force reset, low-line, chip-enable blocking and the battery overrides one edge later;
- a disabled watchdog, or a faulted supply, keeps `wd_n_o` high;
- each fall of `wd_n_o` is followed by a reset.

The following can only be shown by the bench's scenarios:
- the exact pulse widths;
- the spacing of the repeated reset pulses;
- the synchronizer latency of a service change;
- the tie between a service change and an expiring timeout.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Digitized comparator results seen by the supervisor
  typedef struct packed {
    logic vcc_low;
    logic below_bat;
    logic pf_low;
  } sup_flags_t;
endpackage

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic edge_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         prev_q;

  // Synchronizer chain: only the first stage can sample a changing input
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TOP-1:0], d_i};
      end
    end
  endgenerate

  // Hold the previous synchronized level so either direction of change is seen
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[TOP];
  end

  assign edge_o = chain[TOP] ^ prev_q;
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int WD_TICKS = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clear_i,
  input  logic edge_i,
  output logic tmo_o,
  output logic wd_n_o
);
  localparam int CW = $clog2(WD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tmo_o  <= 1'b0;
      wd_n_o <= 1'b1;
    end else if (!en_i || clear_i) begin
      // Disabled, or the supply is faulted: hold the timer cleared
      cnt_q  <= '0;
      tmo_o  <= 1'b0;
      wd_n_o <= 1'b1;
    end else if (edge_i) begin
      // A service change is checked before the timeout, so it wins a tie
      cnt_q  <= '0;
      tmo_o  <= 1'b0;
      wd_n_o <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tmo_o  <= 1'b1;
      wd_n_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tmo_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/sup_rst_pulse.sv
module sup_rst_pulse #(
  parameter int RST_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic trig_i,
  output logic rst_n_o,
  output logic rst_o
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(RST_TICKS);

  logic [CW-1:0] rem_q;
  logic          act;

  // Reset is active while a fault or trigger is present, or the hold-off has not run out
  assign act = hold_i | trig_i | (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= FULL;  // preload so the power-up reset is a full-width pulse
    end else if (hold_i || trig_i) begin
      rem_q <= FULL;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  // Two separate registers for the two polarities of reset
  always_ff @(posedge clk) begin
    if (rst) rst_n_o <= 1'b0;
    else     rst_n_o <= ~act;
  end

  always_ff @(posedge clk) begin
    if (rst) rst_o <= 1'b1;
    else     rst_o <= act;
  end
endmodule

// File: rtl/sup_line_out.sv
module sup_line_out
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sup_flags_t flg_i,
  input  logic       ce_n_i,
  output logic       ce_n_o,
  output logic       low_line_n_o,
  output logic       bat_on_o,
  output logic       pf_n_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n_o       <= 1'b1;
      low_line_n_o <= 1'b0;
      bat_on_o     <= 1'b0;
      pf_n_o       <= 1'b0;
    end else begin
      ce_n_o       <= ce_n_i | flg_i.vcc_low;
      low_line_n_o <= ~(flg_i.vcc_low | flg_i.below_bat);
      bat_on_o     <= flg_i.below_bat;
      pf_n_o       <= ~(flg_i.pf_low | flg_i.below_bat);
    end
  end
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog
  import sup_pkg::*;
#(
  parameter int RST_TICKS   = 16,
  parameter int WD_TICKS    = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vcc_low_i,
  input  logic vcc_below_bat_i,
  input  logic pf_low_i,
  input  logic wd_in_i,
  input  logic wd_en_i,
  input  logic ce_n_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic wd_n_o,
  output logic ce_n_o,
  output logic low_line_n_o,
  output logic bat_on_o,
  output logic pf_n_o
);
  sup_flags_t flg;
  logic       supply_bad;
  logic       wd_edge;
  logic       wd_tmo;

  assign flg.vcc_low   = vcc_low_i;
  assign flg.below_bat = vcc_below_bat_i;
  assign flg.pf_low    = pf_low_i;
  assign supply_bad    = flg.vcc_low | flg.below_bat;

  sup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    (wd_in_i),
    .edge_o (wd_edge)
  );

  sup_wdog #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk     (clk),
    .rst     (rst),
    .en_i    (wd_en_i),
    .clear_i (supply_bad),
    .edge_i  (wd_edge),
    .tmo_o   (wd_tmo),
    .wd_n_o  (wd_n_o)
  );

  sup_rst_pulse #(.RST_TICKS(RST_TICKS)) u_rp (
    .clk     (clk),
    .rst     (rst),
    .hold_i  (supply_bad),
    .trig_i  (wd_tmo),
    .rst_n_o (rst_n_o),
    .rst_o   (rst_o)
  );

  sup_line_out u_lo (
    .clk          (clk),
    .rst          (rst),
    .flg_i        (flg),
    .ce_n_i       (ce_n_i),
    .ce_n_o       (ce_n_o),
    .low_line_n_o (low_line_n_o),
    .bat_on_o     (bat_on_o),
    .pf_n_o       (pf_n_o)
  );
endmodule

// File: rtl/sup_chk.sv
module sup_chk (
  input logic clk,
  input logic rst,
  input logic vcc_low_i,
  input logic vcc_below_bat_i,
  input logic wd_en_i,
  input logic rst_n_o,
  input logic rst_o,
  input logic wd_n_o,
  input logic ce_n_o,
  input logic low_line_n_o,
  input logic bat_on_o,
  input logic pf_n_o
);
  // R4
  rst_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    rst_o == !rst_n_o);

  // R2
  fault_forces_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (vcc_low_i || vcc_below_bat_i) |=> !rst_n_o);

  // R6
  timeout_then_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_n_o) |=> !rst_n_o);

  // R8
  fault_clears_wdog_chk: assert property (@(posedge clk) disable iff (rst)
    (vcc_low_i || vcc_below_bat_i) |=> wd_n_o);

  // R9
  disabled_wdog_high_chk: assert property (@(posedge clk) disable iff (rst)
    !wd_en_i |=> wd_n_o);

  // R10
  low_line_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (vcc_low_i || vcc_below_bat_i) |=> !low_line_n_o);

  // R11
  ce_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    vcc_low_i |=> ce_n_o);

  // R12
  battery_override_chk: assert property (@(posedge clk) disable iff (rst)
    vcc_below_bat_i |=> (!pf_n_o && bat_on_o));
endmodule

bind sup_reset_wdog sup_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .vcc_low_i       (vcc_low_i),
  .vcc_below_bat_i (vcc_below_bat_i),
  .wd_en_i         (wd_en_i),
  .rst_n_o         (rst_n_o),
  .rst_o           (rst_o),
  .wd_n_o          (wd_n_o),
  .ce_n_o          (ce_n_o),
  .low_line_n_o    (low_line_n_o),
  .bat_on_o        (bat_on_o),
  .pf_n_o          (pf_n_o)
);

// File: tb/sim_sup_reset_wdog.sv
`timescale 1ns/1ps
module sim_sup_reset_wdog;
  localparam int RT = 8;
  localparam int WT = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_low = 1'b0, below_bat = 1'b0, pf_low = 1'b0;
  logic wd_in = 1'b0, wd_en = 1'b0, ce_n = 1'b1;
  logic rst_n_o, rst_o, wd_n_o, ce_n_o, low_line_n_o, bat_on_o, pf_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  sup_reset_wdog #(.RST_TICKS(RT), .WD_TICKS(WT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .vcc_low_i(vcc_low), .vcc_below_bat_i(below_bat),
    .pf_low_i(pf_low), .wd_in_i(wd_in), .wd_en_i(wd_en), .ce_n_i(ce_n),
    .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_n_o(wd_n_o), .ce_n_o(ce_n_o),
    .low_line_n_o(low_line_n_o), .bat_on_o(bat_on_o), .pf_n_o(pf_n_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------- behavioural reference model, stepped on every rising edge ----------
  bit hist[$] = '{1'b0, 1'b0, 1'b0};  // newest sample first
  int m_timer = 0;
  int m_left  = RT;
  bit m_tmo = 0, m_wdn = 1, m_rst = 1;
  bit m_ce = 1, m_ll = 0, m_bat = 0, m_pf = 0;

  always @(posedge clk) begin
    bit bad, seen, old_tmo;
    bad = vcc_low | below_bat;
    old_tmo = m_tmo;
    if (rst) begin
      hist = '{1'b0, 1'b0, 1'b0};
      m_timer = 0; m_tmo = 0; m_wdn = 1;
      m_left = RT; m_rst = 1;
      m_ce = 1; m_ll = 0; m_bat = 0; m_pf = 0;
    end else begin
      seen = hist[1] ^ hist[2];
      hist.push_front(wd_in);
      void'(hist.pop_back());
      if (bad || old_tmo) begin m_rst = 1; m_left = RT; end
      else begin m_rst = (m_left != 0); if (m_left != 0) m_left--; end
      if (!wd_en || bad)         begin m_timer = 0; m_tmo = 0; m_wdn = 1; end
      else if (seen)             begin m_timer = 0; m_tmo = 0; m_wdn = 1; end
      else if (m_timer == WT-1)  begin m_timer = 0; m_tmo = 1; m_wdn = 0; end
      else                       begin m_timer++; m_tmo = 0; end
      m_ce  = ce_n | vcc_low;
      m_ll  = !bad;
      m_bat = below_bat;
      m_pf  = !(pf_low | below_bat);
    end
    #1;
    if (cmp_on) begin
      check(rst_n_o == !m_rst, "R3 rst_n_o vs model", rst_n_o, !m_rst);
      check(rst_o == m_rst, "R4 rst_o vs model", rst_o, m_rst);
      check(wd_n_o == m_wdn, "R6 wd_n_o vs model", wd_n_o, m_wdn);
      check(ce_n_o == m_ce, "R11 ce_n_o vs model", ce_n_o, m_ce);
      check(low_line_n_o == m_ll, "R10 low_line_n_o vs model", low_line_n_o, m_ll);
      check(bat_on_o == m_bat && pf_n_o == m_pf, "R12 bat/pf vs model",
            {bat_on_o, pf_n_o}, {m_bat, m_pf});
    end
  end

  // ---------- scenario helpers ----------
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // Number of consecutive samples with rst_n_o low, starting at the next sample
  task automatic count_low(output int n);
    n = 0;
    tick();
    while (rst_n_o == 1'b0 && n < 2000) begin n++; tick(); end
  endtask

  initial begin
    int n;
    ticks(1);
    cmp_on = 1'b1;
    ticks(2);
    // R1 reset state
    check(rst_n_o == 0 && rst_o == 1, "R1 reset lines", {rst_n_o, rst_o}, 2'b01);
    check(wd_n_o == 1 && ce_n_o == 1, "R1 wd/ce", {wd_n_o, ce_n_o}, 2'b11);
    check(low_line_n_o == 0 && pf_n_o == 0 && bat_on_o == 0, "R1 flags",
          {low_line_n_o, pf_n_o, bat_on_o}, 0);
    rst = 1'b0;
    // R3 power-up pulse width
    count_low(n);
    check(n == RT, "R3 power-up width", n, RT);

    // R2 / R10 / R11 low supply
    ce_n = 1'b0;
    vcc_low = 1'b1;
    ticks(4);
    check(rst_n_o == 0, "R2 low supply forces reset", rst_n_o, 0);
    check(low_line_n_o == 0, "R10 low line", low_line_n_o, 0);
    check(ce_n_o == 1, "R11 ce blocked", ce_n_o, 1);
    vcc_low = 1'b0;
    count_low(n);
    check(n == RT, "R3 recovery width", n, RT);
    check(low_line_n_o == 1 && ce_n_o == 0, "R10 R11 after recovery",
          {low_line_n_o, ce_n_o}, 2'b10);

    // R12 battery condition
    below_bat = 1'b1;
    ticks(3);
    check(pf_n_o == 0 && bat_on_o == 1, "R12 battery override", {pf_n_o, bat_on_o}, 2'b01);
    check(rst_n_o == 0, "R2 below battery forces reset", rst_n_o, 0);
    below_bat = 1'b0;
    count_low(n);
    check(n == RT, "R3 width after battery", n, RT);
    pf_low = 1'b1; tick();
    check(pf_n_o == 0 && bat_on_o == 0, "R12 pf low", {pf_n_o, bat_on_o}, 0);
    pf_low = 1'b0; tick();
    check(pf_n_o == 1, "R12 pf high", pf_n_o, 1);
    ce_n = 1'b1; tick();
    check(ce_n_o == 1, "R11 ce follows", ce_n_o, 1);

    // R5 regular service keeps everything quiet
    wd_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      wd_in = ~wd_in;
      for (int j = 0; j < 10; j++) begin
        tick();
        check(wd_n_o == 1 && rst_n_o == 1, "R5 serviced", {wd_n_o, rst_n_o}, 2'b11);
      end
    end

    // R6 missed service
    n = 0;
    while (wd_n_o == 1 && n < 3*WT) begin n++; tick(); end
    check(wd_n_o == 0, "R6 timeout seen", wd_n_o, 0);
    check(rst_n_o == 1, "R6 reset one edge later", rst_n_o, 1);
    count_low(n);
    check(n == RT+1, "R6 pulse width", n, RT+1);
    // R7 repeated pulse spacing
    n = 0;
    while (rst_n_o == 1 && n < 3*WT) begin n++; tick(); end
    check(n == WT-RT-1, "R7 pulse spacing", n, WT-RT-1);
    check(wd_n_o == 0, "R7 wd stays low", wd_n_o, 0);

    // R8 service change restores wd_n_o after the synchronizer latency
    while (rst_n_o == 0) tick();
    wd_in = ~wd_in;
    ticks(2);
    check(wd_n_o == 0, "R5 latency not yet", wd_n_o, 0);
    tick();
    check(wd_n_o == 1, "R8 change restores", wd_n_o, 1);

    // R8 supply fault restores wd_n_o
    n = 0;
    while (wd_n_o == 1 && n < 3*WT) begin n++; tick(); end
    check(wd_n_o == 0, "R6 second timeout", wd_n_o, 0);
    vcc_low = 1'b1; tick();
    check(wd_n_o == 1, "R8 fault restores", wd_n_o, 1);
    vcc_low = 1'b0;
    while (rst_n_o == 0) tick();

    // R9 disabled watchdog
    wd_en = 1'b0;
    for (int j = 0; j < 3*WT; j++) begin
      tick();
      check(wd_n_o == 1 && rst_n_o == 1, "R9 disabled", {wd_n_o, rst_n_o}, 2'b11);
    end

    // R13 service exactly on the timeout edge
    wd_en = 1'b1;
    for (int k = 0; k < 4; k++) begin wd_in = ~wd_in; ticks(5); end
    for (int k = 0; k < 6; k++) begin
      wd_in = ~wd_in;
      for (int j = 0; j < WT; j++) begin
        tick();
        check(wd_n_o == 1 && rst_n_o == 1, "R13 tie favours service",
              {wd_n_o, rst_n_o}, 2'b11);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8*150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule